// File: doc/BRIEF.md
# Halfword Fetch Sequencer with No-Op Folding

This block owns the program counter of a processor whose instructions are either 16 or 32 bits long, packed two halfwords or one fullword to a 32-bit memory word. Bit 1 of the byte-addressed PC says whether the current instruction occupies the right half. The block aligns the fetched word so that the current instruction always sits in bits 31:16, and it advances the PC by 2 or 4 when the instruction retires. An external decoder reports the instruction length. Memory, trap vectoring and execution stay outside the block.

The block runs a two-phase handshake. At an instruction boundary it accepts a fetched word, and it then either takes an interrupt, records a fetch fault, skips a right-half no-op, or issues the instruction. While an instruction is executing, the block waits for completion or a trap. When the no-op folding input is high, a right-half no-op (halfword code 0x0002) that follows a left-half halfword instruction retires together with that instruction, and a right-half no-op fetched on its own is skipped without issue. A one-instruction interrupt shadow follows interrupt entry, a program status load and shadowing control instructions.

Top module: `hw_fetch_seq`

## Requirements
- R1: While rst_ni is low and after reset, pc_o equals RESET_PC (a left-half word address), exec_o is low, and drop_pend_o and inhibit_o are low.
- R2: ir_o equals fetch_word_i when pc_o bit 1 is 0, and fetch_word_i[15:0] followed by 16 zero bits when pc_o bit 1 is 1.
- R3: An issued instruction that retires (done_i high, trap_i low) advances pc_o by 4 if is_half_i was low at issue, and by 2 if it was high and no fold is pending.
- R4: With drop_en_i high, a halfword issued from the left half (pc_o bit 1 = 0) whose word has 0x0002 in bits 15:0 sets drop_pend_o for the execute phase. On retire, pc_o advances by 4 and drop_pend_o clears.
- R5: With drop_en_i high, a boundary at a right-half PC where fetch_word_i[15:0] is 0x0002 asserts skip_o instead of issue_o, advances pc_o by 2 and does not enter execute.
- R6: With drop_en_i low, drop_pend_o never sets and a right-half 0x0002 issues like any other instruction.
- R7: inhibit_o sets and drop_pend_o clears after an interrupt is taken, after a program status load, and after a retire with ctrl_inhibit_i high.
- R8: Issue, skip or fetch fault at a boundary clears inhibit_o, so the shadow covers exactly one instruction.
- R9: An interrupt is taken (irq_take_o, pc_o loads irq_vec_i with bit 0 cleared) only at a boundary with fetch_valid_i high, irq_i high and inhibit_o low. It then takes precedence over fault, skip and issue.
- R10: A fetch fault at a boundary or a trap at completion leaves pc_o unchanged, clears drop_pend_o and returns to the boundary.
- R11: psd_load_i in any phase loads psd_pc_i with bit 0 cleared, returns to the boundary, and overrides every other event of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drop_en_i | input | 1 | Model select: enables no-op folding and skipping |
| fetch_valid_i | input | 1 | Fetched word present at the boundary |
| fetch_word_i | input | 32 | Fetched memory word |
| fetch_fault_i | input | 1 | Fetch of the current word faulted |
| is_half_i | input | 1 | Decoder: aligned instruction is a halfword |
| done_i | input | 1 | Executing instruction completes this cycle |
| trap_i | input | 1 | Completion is a trap (with done_i) |
| ctrl_inhibit_i | input | 1 | Retiring instruction shadows the next interrupt test |
| irq_i | input | 1 | Interrupt request |
| irq_vec_i | input | PC_W | Interrupt entry address |
| psd_load_i | input | 1 | Load a new program status |
| psd_pc_i | input | PC_W | PC carried by the program status load |
| pc_o | output | PC_W | Program counter (byte address) |
| ir_o | output | 32 | Aligned instruction word |
| issue_o | output | 1 | Instruction issued this cycle |
| skip_o | output | 1 | Right-half no-op skipped this cycle |
| irq_take_o | output | 1 | Interrupt taken this cycle |
| exec_o | output | 1 | Execute phase in progress |
| drop_pend_o | output | 1 | Right-half no-op folded into current instruction |
| inhibit_o | output | 1 | Interrupt test shadowed for the next boundary |

## Verification
Two functions meet at the same boundary: the interrupt test and the right-half no-op skip. Both can act on one fetched word, and the interrupt shadow decides which one applies. Directed cases present a skippable right-half no-op together with irq_i, once with the shadow open (the interrupt wins and the PC takes the vector) and once just after a program status load (the skip wins and the shadow is consumed). Constrained random traffic biases both halfwords toward 0x0002 and mixes interrupts, faults, traps and loads. A cycle model computed in the bench judges every boundary outcome and every PC step.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  localparam int IW = 32;
  localparam int HW = IW / 2;
  localparam logic [HW-1:0] HW_NOP = 16'h0002;

  typedef enum logic {
    ST_BOUND,
    ST_EXEC
  } seq_st_e;

  typedef enum logic [2:0] {
    PC_HOLD,
    PC_LOAD,
    PC_VEC,
    PC_ADD2,
    PC_ADD4
  } pc_sel_e;
endpackage

// File: rtl/hfs_align.sv
module hfs_align
  import hfs_pkg::*;
(
  input  logic [IW-1:0] word_i,
  input  logic          right_i,
  output logic [IW-1:0] ir_o,
  output logic          rt_nop_o,   // right-half slot holds the no-op
  output logic          tail_nop_o  // left-half fetch with no-op in its right half
);
  logic tail_is_nop;

  assign tail_is_nop = (word_i[HW-1:0] == HW_NOP);

  always_comb begin
    if (right_i) ir_o = {word_i[HW-1:0], {HW{1'b0}}};
    else         ir_o = word_i;
  end

  assign rt_nop_o   = right_i & tail_is_nop;
  assign tail_nop_o = ~right_i & tail_is_nop;
endmodule

// File: rtl/hfs_pc.sv
module hfs_pc
  import hfs_pkg::*;
#(
  parameter int              PC_W     = 24,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  pc_sel_e         sel_i,
  input  logic [PC_W-1:0] load_val_i,
  input  logic [PC_W-1:0] vec_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] STEP_H = PC_W'(2);
  localparam logic [PC_W-1:0] STEP_F = PC_W'(4);
  localparam logic [PC_W-1:0] ODD_CLR = ~PC_W'(1);

  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    unique case (sel_i)
      PC_LOAD: pc_d = load_val_i & ODD_CLR;
      PC_VEC:  pc_d = vec_i & ODD_CLR;
      PC_ADD2: pc_d = pc_q + STEP_H;
      PC_ADD4: pc_d = pc_q + STEP_F;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  AST_PC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i != PC_HOLD |=> pc_q[0] == 1'b0);  // R11
endmodule

// File: rtl/hfs_flags.sv
module hfs_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drop_clr_i,
  input  logic drop_load_i,
  input  logic drop_val_i,
  input  logic inh_set_i,
  input  logic inh_clr_i,
  output logic drop_o,
  output logic inh_o
);
  logic drop_q, inh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drop_q <= 1'b0;
      inh_q  <= 1'b0;
    end else begin
      if (drop_clr_i)       drop_q <= 1'b0;
      else if (drop_load_i) drop_q <= drop_val_i;

      if (inh_set_i)      inh_q <= 1'b1;
      else if (inh_clr_i) inh_q <= 1'b0;
    end
  end

  assign drop_o = drop_q;
  assign inh_o  = inh_q;

  AST_INH_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_set_i |=> inh_q);  // R7
endmodule

// File: rtl/hw_fetch_seq.sv
module hw_fetch_seq
  import hfs_pkg::*;
#(
  parameter int              PC_W     = 24,
  parameter logic [PC_W-1:0] RESET_PC = 24'h000100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            drop_en_i,
  input  logic            fetch_valid_i,
  input  logic [31:0]     fetch_word_i,
  input  logic            fetch_fault_i,
  input  logic            is_half_i,
  input  logic            done_i,
  input  logic            trap_i,
  input  logic            ctrl_inhibit_i,
  input  logic            irq_i,
  input  logic [PC_W-1:0] irq_vec_i,
  input  logic            psd_load_i,
  input  logic [PC_W-1:0] psd_pc_i,
  output logic [PC_W-1:0] pc_o,
  output logic [31:0]     ir_o,
  output logic            issue_o,
  output logic            skip_o,
  output logic            irq_take_o,
  output logic            exec_o,
  output logic            drop_pend_o,
  output logic            inhibit_o
);
  localparam logic [PC_W-1:0] STEP_H = PC_W'(2);
  localparam logic [PC_W-1:0] STEP_F = PC_W'(4);

  seq_st_e st_q, st_d;
  pc_sel_e pc_sel;
  logic    half_q;
  logic    rt_nop, tail_nop;
  logic    boundary, irq_take, fault_b, skip, issue;
  logic    complete, trap_c, retire;

  hfs_align u_align (
    .word_i     (fetch_word_i),
    .right_i    (pc_o[1]),
    .ir_o       (ir_o),
    .rt_nop_o   (rt_nop),
    .tail_nop_o (tail_nop)
  );

  // boundary outcome priority: load > interrupt > fault > skip > issue
  assign boundary = (st_q == ST_BOUND) & fetch_valid_i & ~psd_load_i;
  assign irq_take = boundary & irq_i & ~inhibit_o;
  assign fault_b  = boundary & ~irq_take & fetch_fault_i;
  assign skip     = boundary & ~irq_take & ~fetch_fault_i & drop_en_i & rt_nop;
  assign issue    = boundary & ~irq_take & ~fetch_fault_i & ~skip;

  assign complete = (st_q == ST_EXEC) & done_i & ~psd_load_i;
  assign trap_c   = complete & trap_i;
  assign retire   = complete & ~trap_i;

  always_comb begin
    pc_sel = PC_HOLD;
    if (psd_load_i)    pc_sel = PC_LOAD;
    else if (irq_take) pc_sel = PC_VEC;
    else if (skip)     pc_sel = PC_ADD2;
    else if (retire)   pc_sel = (half_q && !drop_pend_o) ? PC_ADD2 : PC_ADD4;
  end

  always_comb begin
    st_d = st_q;
    if (psd_load_i)    st_d = ST_BOUND;
    else if (issue)    st_d = ST_EXEC;
    else if (complete) st_d = ST_BOUND;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_BOUND;
      half_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (issue) half_q <= is_half_i;
    end
  end

  hfs_pc #(
    .PC_W     (PC_W),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (pc_sel),
    .load_val_i (psd_pc_i),
    .vec_i      (irq_vec_i),
    .pc_o       (pc_o)
  );

  hfs_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drop_clr_i  (psd_load_i | irq_take | fault_b | complete),
    .drop_load_i (issue),
    .drop_val_i  (drop_en_i & tail_nop & is_half_i),
    .inh_set_i   (psd_load_i | irq_take | (retire & ctrl_inhibit_i)),
    .inh_clr_i   (issue | skip | fault_b),
    .drop_o      (drop_pend_o),
    .inh_o       (inhibit_o)
  );

  assign issue_o    = issue;
  assign skip_o     = skip;
  assign irq_take_o = irq_take;
  assign exec_o     = (st_q == ST_EXEC);

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_take_o, fault_b, skip_o, issue_o}));  // R9
  AST_SKIP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> pc_o == $past(pc_o) + STEP_H && !exec_o);  // R5
  AST_FULL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire && !half_q |=> pc_o == $past(pc_o) + STEP_F);  // R3
  AST_HALF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire && half_q && !drop_pend_o |=> pc_o == $past(pc_o) + STEP_H);  // R3
  AST_FOLD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire && drop_pend_o |=> pc_o == $past(pc_o) + STEP_F && !drop_pend_o);  // R4
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_b || trap_c |=> pc_o == $past(pc_o) && !drop_pend_o && !exec_o);  // R10
  AST_NO_FOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && !drop_en_i |=> !drop_pend_o);  // R6
  AST_TAKE_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |=> inhibit_o && !drop_pend_o && !exec_o);  // R7
  AST_SHADOW_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_o && (issue_o || skip_o) |=> !inhibit_o);  // R8
  AST_LOAD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psd_load_i |=> !exec_o && inhibit_o);  // R11
endmodule

// File: tb/hw_fetch_seq_tb.sv
`timescale 1ns/1ps
module hw_fetch_seq_tb;
  localparam int PC_W = 24;
  localparam logic [PC_W-1:0] RST_PC = 24'h000100;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic            den, fv, flt, half, dn, tr, ci, irq, ld;
  logic [31:0]     w;
  logic [PC_W-1:0] vec, ldpc;
  logic [PC_W-1:0] pc_o;
  logic [31:0]     ir_o;
  logic issue_o, skip_o, irq_take_o, exec_o, drop_pend_o, inhibit_o;

  hw_fetch_seq #(.PC_W(PC_W), .RESET_PC(RST_PC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .drop_en_i(den), .fetch_valid_i(fv),
    .fetch_word_i(w), .fetch_fault_i(flt), .is_half_i(half), .done_i(dn),
    .trap_i(tr), .ctrl_inhibit_i(ci), .irq_i(irq), .irq_vec_i(vec),
    .psd_load_i(ld), .psd_pc_i(ldpc), .pc_o(pc_o), .ir_o(ir_o),
    .issue_o(issue_o), .skip_o(skip_o), .irq_take_o(irq_take_o),
    .exec_o(exec_o), .drop_pend_o(drop_pend_o), .inhibit_o(inhibit_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [PC_W-1:0] m_pc;
  logic m_drop, m_inh, m_exec, m_half;
  string m_tag;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    fv = 0; w = '0; flt = 0; half = 0; dn = 0; tr = 0; ci = 0;
    irq = 0; ld = 0; vec = 24'h000800; ldpc = '0;
  endtask

  function automatic logic [31:0] align(logic [31:0] x, logic right);
    return right ? {x[15:0], 16'h0000} : x;
  endfunction

  // one clock: inputs already driven at the falling edge
  task automatic cycle();
    logic bnd, e_irq, e_flt, e_skip, e_issue, rt_nop, cpl, ret;
    #1;
    bnd     = !m_exec && fv && !ld;
    e_irq   = bnd && irq && !m_inh;
    e_flt   = bnd && !e_irq && flt;
    rt_nop  = m_pc[1] && (w[15:0] == 16'h0002);
    e_skip  = bnd && !e_irq && !flt && den && rt_nop;
    e_issue = bnd && !e_irq && !flt && !e_skip;
    cpl     = m_exec && dn && !ld;
    ret     = cpl && !tr;
    chk("R2", "ir_o", ir_o, align(w, m_pc[1]));
    chk("R9", "irq_take_o", 32'(irq_take_o), 32'(e_irq));
    chk(den ? "R5" : "R6", "skip_o", 32'(skip_o), 32'(e_skip));
    chk(den ? "R5" : "R6", "issue_o", 32'(issue_o), 32'(e_issue));
    m_tag = "R10";
    if (ld) begin
      m_pc = ldpc & ~24'h1; m_inh = 1; m_drop = 0; m_exec = 0; m_tag = "R11";
    end else if (e_irq) begin
      m_pc = vec & ~24'h1; m_inh = 1; m_drop = 0; m_tag = "R9";
    end else if (e_flt) begin
      m_drop = 0; m_inh = 0; m_tag = "R10";
    end else if (e_skip) begin
      m_pc = m_pc + 2; m_inh = 0; m_tag = "R5";
    end else if (e_issue) begin
      m_inh = 0; m_exec = 1; m_half = half;
      m_drop = den && !m_pc[1] && half && (w[15:0] == 16'h0002);
      m_tag = den ? "R4" : "R6";
    end else if (cpl) begin
      if (ret) begin
        m_pc = m_pc + ((m_half && !m_drop) ? 2 : 4);
        if (ci) m_inh = 1;
        m_tag = m_drop ? "R4" : "R3";
      end
      m_drop = 0; m_exec = 0;
    end
    @(posedge clk);
    #1;
    chk(m_tag, "pc_o", 32'(pc_o), 32'(m_pc));
    chk(m_tag, "exec_o", 32'(exec_o), 32'(m_exec));
    chk("R4", "drop_pend_o", 32'(drop_pend_o), 32'(m_drop));
    chk(m_inh ? "R7" : "R8", "inhibit_o", 32'(inhibit_o), 32'(m_inh));
    @(negedge clk);
  endtask

  task automatic load(logic [PC_W-1:0] a);
    idle_in(); ld = 1; ldpc = a; cycle();
  endtask
  task automatic fetch(logic [31:0] x, logic h);
    idle_in(); fv = 1; w = x; half = h; cycle();
  endtask
  task automatic finish_ins(logic c);
    idle_in(); dn = 1; ci = c; cycle();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_in(); den = 1;
    m_pc = RST_PC; m_drop = 0; m_inh = 0; m_exec = 0; m_half = 0;
    repeat (3) @(negedge clk);
    chk("R1", "pc_o in reset", 32'(pc_o), 32'(RST_PC));
    chk("R1", "flags in reset", {29'd0, exec_o, drop_pend_o, inhibit_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1", "pc_o after reset", 32'(pc_o), 32'(RST_PC));

    // R4 fold: left halfword with no-op tail retires as fullword
    fetch(32'h1234_0002, 1);
    chk("R4", "fold pending", 32'(drop_pend_o), 32'd1);
    finish_ins(0);
    chk("R4", "fold advance", 32'(pc_o), 32'h104);
    // R6 no fold with model select low; right no-op issues
    den = 0;
    fetch(32'h1234_0002, 1);
    finish_ins(0);
    chk("R6", "no fold advance", 32'(pc_o), 32'h106);
    fetch(32'h1234_0002, 1);
    chk("R6", "right no-op executes", 32'(exec_o), 32'd1);
    finish_ins(0);
    den = 1;
    // R5 + R8: skip consumes shadow, interrupt not taken in shadow
    load(24'h000202);
    idle_in(); fv = 1; w = 32'hABCD_0002; irq = 1; cycle();
    chk("R5", "skip under shadow pc", 32'(pc_o), 32'h204);
    chk("R8", "shadow consumed", 32'(inhibit_o), 32'd0);
    // R9: shadow open, interrupt beats a skippable no-op
    load(24'h000302); fetch(32'h0000_1111, 0); finish_ins(0);
    idle_in(); fv = 1; w = 32'h5555_0002; irq = 1; vec = 24'h000901; cycle();
    chk("R9", "vector taken", 32'(pc_o), 32'h900);
    // R7: ctrl inhibit retire blocks next interrupt
    fetch(32'h2222_3333, 0); finish_ins(1);
    idle_in(); fv = 1; w = 32'h4444_5555; irq = 1; cycle();
    chk("R7", "irq blocked after ctrl inhibit", 32'(exec_o), 32'd1);
    // R10: trap with fold pending holds pc
    finish_ins(0);
    fetch(32'h7777_0002, 1);
    idle_in(); dn = 1; tr = 1; cycle();
    chk("R10", "trap holds pc", 32'(pc_o), 32'h908);
    idle_in(); fv = 1; flt = 1; cycle();
    chk("R10", "fault holds pc", 32'(pc_o), 32'h908);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      idle_in();
      if (i % 500 == 0) den = $urandom_range(0, 1);
      fv   = ($urandom_range(0, 9) < 8);
      w    = $urandom;
      if ($urandom_range(0, 9) < 4) w[15:0] = 16'h0002;
      if ($urandom_range(0, 9) < 3) w[31:16] = 16'h0002;
      half = $urandom_range(0, 1);
      flt  = ($urandom_range(0, 19) == 0);
      dn   = ($urandom_range(0, 9) < 6);
      tr   = ($urandom_range(0, 19) == 0);
      ci   = ($urandom_range(0, 4) == 0);
      irq  = ($urandom_range(0, 9) == 0);
      vec  = 24'($urandom);
      ld   = ($urandom_range(0, 39) == 0);
      ldpc = 24'($urandom);
      cycle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule